// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Accumulator Bank

This block sits beside an integer pipeline and performs integer multiplies, multiply-accumulates and divides on two 32-bit operands. Its results go into one of four 64-bit accumulator pairs, each made of a high word and a low word. A 2-bit field chooses the pair, and pair 0 is the usual target. One operation is offered per cycle through a valid/stall handshake. An offered operation is taken on a rising edge where `stall` is low. While `stall` is high, the issuer keeps the operation steady.

Multiplies run on one shared 32x16 signed array. When the second operand fits in 16 bits, the product comes out of a single pass. This means the operand is the sign extension of its low half for signed forms, or has a zero upper half for unsigned forms. Any other second operand needs a second pass through the array, and that pass holds the unit for one cycle. Divides use a restoring loop that produces one quotient bit per clock. The divide keeps the unit busy until it finishes. The quotient then goes to the low word and the remainder to the high word.

There is a low-word multiply whose 32-bit result returns on the result port. Two read-back operations return the high or the low word of a pair on that same port.

Top module: `mdu_core`

## Requirements
- R1: After reset all four accumulator pairs read as zero, and `stall` and `res_valid` are low.
- R2: Opcodes: 0 signed multiply, 1 unsigned multiply, 2 signed multiply-add, 3 unsigned multiply-add, 4 signed multiply-subtract, 5 unsigned multiply-subtract, 6 low-word multiply (signed), 7 signed divide, 8 unsigned divide, 9 read high word, 10 read low word. Opcodes 0 and 1 write the full 64-bit product into the pair chosen by `iss_sel` and leave the other pairs unchanged.
- R3: Opcodes 2 and 3 add the 64-bit product to the chosen pair, and opcodes 4 and 5 subtract it, both modulo 2^64.
- R4: A multiply whose second operand fits in 16 bits lets the next operation be taken in the following cycle. Any other multiply raises `stall` for exactly one cycle, so an operation that follows it directly waits one cycle.
- R5: Opcode 6 pulses `res_valid` with the low 32 bits of the signed product. The pulse comes one cycle after acceptance for a narrow operand and two cycles after for a wide one. No accumulator pair changes.
- R6: A divide leaves the quotient in the low word and the remainder in the high word. A signed divide truncates toward zero, and its remainder takes the dividend's sign. The most negative dividend divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: After a divide is accepted, `stall` stays high for exactly 33 cycles. An operation offered during that time is taken only once, after the divide completes.
- R8: Dividing by zero gives a high word equal to the dividend. The low word is 0xFFFFFFFF, except for a signed divide of a negative dividend, where it is 1.
- R9: Opcodes 9 and 10 return the chosen pair's high or low word on `res_data`, with `res_valid` high, one cycle after acceptance. The value reflects every operation accepted earlier, including one still completing when the read was offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An operation is offered this cycle |
| iss_op | input | 4 | Opcode of the offered operation |
| iss_a | input | 32 | First operand (multiplicand or dividend) |
| iss_b | input | 32 | Second operand (multiplier or divisor) |
| iss_sel | input | 2 | Accumulator pair select |
| stall | output | 1 | Unit cannot take an operation this cycle |
| res_valid | output | 1 | One-cycle strobe qualifying `res_data` |
| res_data | output | 32 | Low-word product or accumulator read-back |

## Verification
The bench builds the unit with its default parameters: 32-bit operands, a 16-bit array half and four accumulator pairs. With these values the narrow/wide boundary sits at ordinary 32-bit constants such as 32767, -32768, 32768 and 65535. The 2-bit select reaches every pair, including the check that pairs not selected stay unchanged. A 32-bit divide sets the 33-cycle occupancy, which is short enough to measure exactly for every directed and random divide.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [3:0] {
    OP_MULS  = 4'd0,
    OP_MULU  = 4'd1,
    OP_MACS  = 4'd2,
    OP_MACU  = 4'd3,
    OP_MSBS  = 4'd4,
    OP_MSBU  = 4'd5,
    OP_MULLO = 4'd6,
    OP_DIVS  = 4'd7,
    OP_DIVU  = 4'd8,
    OP_RDHI  = 4'd9,
    OP_RDLO  = 4'd10
  } mdu_op_e;

  function automatic logic op_signed(mdu_op_e op);
    return op inside {OP_MULS, OP_MACS, OP_MSBS, OP_MULLO, OP_DIVS};
  endfunction

  function automatic logic op_is_mul(mdu_op_e op);
    return op inside {OP_MULS, OP_MULU, OP_MACS, OP_MACU, OP_MSBS, OP_MSBU, OP_MULLO};
  endfunction

  function automatic logic op_is_div(mdu_op_e op);
    return op inside {OP_DIVS, OP_DIVU};
  endfunction

  function automatic logic op_is_read(mdu_op_e op);
    return op inside {OP_RDHI, OP_RDLO};
  endfunction

endpackage

// File: rtl/mdu_mulpass.sv
// One pass through the shared signed array: (W+1) x (H+1) bits.
module mdu_mulpass #(
  parameter int W = 32,
  parameter int H = 16,
  localparam int PW = W + H + 2
) (
  input  logic signed [W:0]    a_x,
  input  logic signed [H:0]    b_x,
  output logic signed [PW-1:0] p
);
  assign p = a_x * b_x;
endmodule

// File: rtl/mdu_divider.sv
// Restoring radix-2 divider on magnitudes, with the signs fixed afterwards.
module mdu_divider #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [CW-1:0] cnt;
  logic [W-1:0]  r_q, q_q, d_q;
  logic          neg_q, neg_r;

  function automatic logic [W-1:0] magnitude(logic [W-1:0] v, logic s);
    return (s && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  // Bring in one dividend bit and subtract the divisor when it fits.
  function automatic logic [2*W-1:0] restore_step(logic [W-1:0] r, logic [W-1:0] q,
                                                  logic [W-1:0] d);
    logic [W:0] t;
    logic [W:0] diff;
    t    = {r, q[W-1]};
    diff = t - {1'b0, d};
    if (t >= {1'b0, d}) return {diff[W-1:0], q[W-2:0], 1'b1};
    else                return {t[W-1:0],    q[W-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      r_q   <= '0;
      q_q   <= '0;
      d_q   <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt   <= CW'(W);
      r_q   <= '0;
      q_q   <= magnitude(dvd, sgn);
      d_q   <= magnitude(dvs, sgn);
      neg_q <= sgn & (dvd[W-1] ^ dvs[W-1]);
      neg_r <= sgn & dvd[W-1];
    end else if (busy) begin
      if (cnt != '0) begin
        {r_q, q_q} <= restore_step(r_q, q_q, d_q);
        cnt        <= cnt - 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign done = busy && (cnt == '0);
  assign quo  = neg_q ? (~q_q + 1'b1) : q_q;
  assign rem  = neg_r ? (~r_q + 1'b1) : r_q;
endmodule

// File: rtl/mdu_accbank.sv
module mdu_accbank #(
  parameter int NACC = 4,
  parameter int AW   = 64,
  localparam int SEL_W = $clog2(NACC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [AW-1:0]    wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [AW-1:0]    rdata
);
  logic [AW-1:0] rows [NACC];

  for (genvar g = 0; g < NACC; g++) begin : g_pair
    logic [AW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && wsel == SEL_W'(g))    q <= wdata;
    end
    assign rows[g] = q;
  end

  assign rdata = rows[rsel];
endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
#(
  parameter int W    = 32,
  parameter int NACC = 4,
  localparam int SEL_W = $clog2(NACC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [3:0]       iss_op,
  input  logic [W-1:0]     iss_a,
  input  logic [W-1:0]     iss_b,
  input  logic [SEL_W-1:0] iss_sel,
  output logic             stall,
  output logic             res_valid,
  output logic [W-1:0]     res_data
);
  localparam int H  = W / 2;
  localparam int AW = 2 * W;
  localparam int PW = W + H + 2;

  // ---- arithmetic helpers ----
  function automatic logic fits_half(logic [W-1:0] b, logic s);
    if (s) return (&b[W-1:H-1]) | ~(|b[W-1:H-1]);
    else   return ~(|b[W-1:H]);
  endfunction

  function automatic logic [AW-1:0] widen(logic [PW-1:0] p);
    return {{(AW-PW){p[PW-1]}}, p};
  endfunction

  function automatic logic [AW-1:0] fold(mdu_op_e o, logic [AW-1:0] acc, logic [AW-1:0] prod);
    case (o)
      OP_MACS, OP_MACU: return acc + prod;
      OP_MSBS, OP_MSBU: return acc - prod;
      default:          return prod;
    endcase
  endfunction

  // ---- issue decode ----
  mdu_op_e op;
  logic    sgn, narrow;
  logic    issue_ok, take_narrow, take_wide, div_start, iss_rd;
  logic [W:0] a_x;
  logic [H:0] b_first_x, b_hi_x;

  // pass-two state
  logic             in_mul2;
  logic [W:0]       m2_a;
  logic [H:0]       m2_b;
  logic [AW-1:0]    m2_lo;
  mdu_op_e          m2_op;
  logic [SEL_W-1:0] m2_sel;

  // divider
  logic             dv_busy, div_done;
  logic [W-1:0]     dv_quo, dv_rem;
  logic [SEL_W-1:0] dv_sel;

  assign op          = mdu_op_e'(iss_op);
  assign stall       = in_mul2 | dv_busy;
  assign issue_ok    = iss_valid & ~stall;
  assign sgn         = op_signed(op);
  assign narrow      = fits_half(iss_b, sgn);
  assign take_narrow = issue_ok & op_is_mul(op) & narrow;
  assign take_wide   = issue_ok & op_is_mul(op) & ~narrow;
  assign div_start   = issue_ok & op_is_div(op);
  assign iss_rd      = issue_ok & op_is_read(op);

  assign a_x       = {sgn & iss_a[W-1], iss_a};
  assign b_first_x = {narrow & sgn & iss_b[H-1], iss_b[H-1:0]};
  assign b_hi_x    = {sgn & iss_b[W-1], iss_b[W-1:H]};

  // ---- shared array ----
  logic [W:0]    pa;
  logic [H:0]    pb;
  logic [PW-1:0] pp;
  logic [AW-1:0] prod_full;

  assign pa = in_mul2 ? m2_a : a_x;
  assign pb = in_mul2 ? m2_b : b_first_x;

  mdu_mulpass #(.W(W), .H(H)) i_array (.a_x(pa), .b_x(pb), .p(pp));

  assign prod_full = in_mul2 ? (m2_lo + (widen(pp) << H)) : widen(pp);

  // ---- multiply completion ----
  logic             fin, fin_lowonly;
  mdu_op_e          fin_op;
  logic [SEL_W-1:0] fin_sel;

  assign fin         = take_narrow | in_mul2;
  assign fin_op      = in_mul2 ? m2_op  : op;
  assign fin_sel     = in_mul2 ? m2_sel : iss_sel;
  assign fin_lowonly = fin & (fin_op == OP_MULLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mul2 <= 1'b0;
      m2_a    <= '0;
      m2_b    <= '0;
      m2_lo   <= '0;
      m2_op   <= OP_MULS;
      m2_sel  <= '0;
    end else begin
      in_mul2 <= take_wide;
      if (take_wide) begin
        m2_a   <= a_x;
        m2_b   <= b_hi_x;
        m2_lo  <= widen(pp);
        m2_op  <= op;
        m2_sel <= iss_sel;
      end
    end
  end

  // ---- divider ----
  mdu_divider #(.W(W)) i_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .sgn(sgn),
    .dvd(iss_a), .dvs(iss_b), .busy(dv_busy), .done(div_done),
    .quo(dv_quo), .rem(dv_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dv_sel <= '0;
    else if (div_start) dv_sel <= iss_sel;
  end

  // ---- accumulator bank ----
  logic             acc_we;
  logic [SEL_W-1:0] acc_wsel, acc_rsel;
  logic [AW-1:0]    acc_wdata, acc_rdata;

  assign acc_rsel = fin_sel;
  always_comb begin
    acc_we    = 1'b0;
    acc_wsel  = fin_sel;
    acc_wdata = fold(fin_op, acc_rdata, prod_full);
    if (div_done) begin
      acc_we    = 1'b1;
      acc_wsel  = dv_sel;
      acc_wdata = {dv_rem, dv_quo};
    end else if (fin && !fin_lowonly) begin
      acc_we    = 1'b1;
    end
  end

  mdu_accbank #(.NACC(NACC), .AW(AW)) i_bank (
    .clk(clk), .rst_n(rst_n), .we(acc_we), .wsel(acc_wsel), .wdata(acc_wdata),
    .rsel(acc_rsel), .rdata(acc_rdata)
  );

  // ---- result port ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= fin_lowonly | iss_rd;
      if (fin_lowonly)  res_data <= prod_full[W-1:0];
      else if (iss_rd)  res_data <= (op == OP_RDHI) ? acc_rdata[AW-1:W] : acc_rdata[W-1:0];
    end
  end
endmodule

// File: rtl/mdu_core_chk.sv
module mdu_core_chk (
  input logic clk,
  input logic rst_n,
  input logic stall,
  input logic res_valid,
  input logic take_wide,
  input logic in_mul2,
  input logic div_start,
  input logic div_done,
  input logic fin_lowonly,
  input logic acc_we,
  input logic iss_rd
);
  // R4: a wide multiply holds the unit for its second pass
  p_wide_interlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_wide |=> stall);

  // R4: the second pass lasts a single cycle
  p_pass_two_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_mul2 |=> !in_mul2);

  // R7: a divide blocks the unit from the next cycle on
  p_div_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> stall);

  // R7: completion of a divide frees the unit
  p_div_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> !stall);

  // R5: the low-word multiply writes no accumulator
  p_lowonly_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_lowonly |-> !acc_we);

  // R9: a read produces a result strobe one cycle later
  p_read_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_rd |=> res_valid);
endmodule

bind mdu_core mdu_core_chk i_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .res_valid(res_valid),
  .take_wide(take_wide), .in_mul2(in_mul2), .div_start(div_start),
  .div_done(div_done), .fin_lowonly(fin_lowonly), .acc_we(acc_we), .iss_rd(iss_rd)
);

// File: tb/test_mdu_core.sv
`timescale 1ns/1ps
module test_mdu_core;
  localparam logic [3:0] C_MULS = 4'd0, C_MULU = 4'd1, C_MACS = 4'd2, C_MACU = 4'd3,
                         C_MSBS = 4'd4, C_MSBU = 4'd5, C_MULLO = 4'd6, C_DIVS = 4'd7,
                         C_DIVU = 4'd8, C_RDHI = 4'd9, C_RDLO = 4'd10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_op = '0;
  logic [31:0] iss_a = '0, iss_b = '0;
  logic [1:0]  iss_sel = '0;
  logic        stall, res_valid;
  logic [31:0] res_data;

  int total = 0, bad = 0;
  logic [63:0] mdl [4];

  always #10 clk = ~clk;

  mdu_core i_mdu_core (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a(iss_a), .iss_b(iss_b), .iss_sel(iss_sel),
    .stall(stall), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic signed_form(logic [3:0] op);
    return op == C_MULS || op == C_MACS || op == C_MSBS || op == C_MULLO || op == C_DIVS;
  endfunction

  function automatic logic [63:0] ref_prod(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    if (signed_form(op)) begin
      sa = $signed(a);
      sb = $signed(b);
      return sa * sb;
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  function automatic logic ref_narrow(logic [3:0] op, logic [31:0] b);
    longint sb;
    sb = $signed(b);
    if (signed_form(op)) return sb >= -32768 && sb <= 32767;
    return b < 32'd65536;
  endfunction

  function automatic logic [63:0] ref_div(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    if (b == 32'd0)
      return {a, ((op == C_DIVS) && a[31]) ? 32'd1 : 32'hFFFF_FFFF};
    if (op == C_DIVS) begin
      sa = $signed(a);
      sb = $signed(b);
      q = sa / sb;
      r = sa % sb;
      return {r[31:0], q[31:0]};
    end
    return {a % b, a / b};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; w counts cycles spent waiting on stall.
  task automatic put(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [1:0] s,
                     output int w);
    iss_valid = 1'b1; iss_op = op; iss_a = a; iss_b = b; iss_sel = s;
    w = 0;
    while (stall) begin
      @(negedge clk);
      w++;
    end
    @(posedge clk);
    @(negedge clk);
    iss_valid = 1'b0;
    case (op)
      C_MULS, C_MULU: mdl[s] = ref_prod(op, a, b);
      C_MACS, C_MACU: mdl[s] = mdl[s] + ref_prod(op, a, b);
      C_MSBS, C_MSBU: mdl[s] = mdl[s] - ref_prod(op, a, b);
      C_DIVS, C_DIVU: mdl[s] = ref_div(op, a, b);
      default: ;
    endcase
  endtask

  task automatic read_pair(logic [1:0] s, string tag);
    int w;
    put(C_RDHI, 32'd0, 32'd0, s, w);
    check({tag, " hi"}, {res_valid, res_data}, {1'b1, mdl[s][63:32]});
    put(C_RDLO, 32'd0, 32'd0, s, w);
    check({tag, " lo"}, {res_valid, res_data}, {1'b1, mdl[s][31:0]});
  endtask

  task automatic read_all(string tag);
    for (int k = 0; k < 4; k++) read_pair(2'(k), tag);
  endtask

  // Low-word multiply: value, latency and untouched pairs (R5)
  task automatic low_mul(logic [31:0] a, logic [31:0] b);
    int w, lat;
    logic [63:0] p;
    p = ref_prod(C_MULLO, a, b);
    put(C_MULLO, a, b, 2'd0, w);
    lat = 1;
    while (!res_valid && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    check("R5 low-word value", {32'd0, res_data}, {32'd0, p[31:0]});
    check("R5 latency", 64'(lat), ref_narrow(C_MULLO, b) ? 64'd1 : 64'd2);
    read_all("R5 pairs unchanged");
  endtask

  // Divide followed by a read that must wait out the whole divide (R6, R7, R8)
  task automatic divide(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [1:0] s,
                        string tag);
    int w;
    put(op, a, b, s, w);
    put(C_RDHI, 32'd0, 32'd0, s, w);
    check("R7 divide occupancy", 64'(w), 64'd33);
    check({tag, " remainder"}, {32'd0, res_data}, {32'd0, mdl[s][63:32]});
    put(C_RDLO, 32'd0, 32'd0, s, w);
    check({tag, " quotient"}, {32'd0, res_data}, {32'd0, mdl[s][31:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    logic [3:0] op;
    logic [31:0] a, b;
    logic [1:0] s;
    void'($urandom(32'd20240607));
    for (int k = 0; k < 4; k++) mdl[k] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 stall after reset", {63'd0, stall}, 64'd0);
    check("R1 res_valid after reset", {63'd0, res_valid}, 64'd0);
    read_all("R1 pairs zero");

    // R2: plain multiply to pair 1 only
    put(C_MULS, 32'hFFFF_FFFD, 32'd5, 2'd1, w);
    read_all("R2 signed multiply");
    put(C_MULU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, w);
    read_all("R2 unsigned multiply");

    // R4: narrow then narrow issues without waiting
    put(C_MULS, 32'h1234_5678, 32'hFFFF_8000, 2'd0, w);
    put(C_MACS, 32'h8000_0000, 32'd32767, 2'd0, w);
    check("R4 narrow follow-on wait", 64'(w), 64'd0);
    // R4: wide then any operation waits one cycle
    put(C_MULS, 32'h1234_5678, 32'd32768, 2'd3, w);
    put(C_MACU, 32'hDEAD_BEEF, 32'd65535, 2'd0, w);
    check("R4 wide follow-on wait", 64'(w), 64'd1);
    put(C_MULU, 32'hDEAD_BEEF, 32'd65536, 2'd3, w);
    put(C_MULU, 32'hCAFE_F00D, 32'hFFFF_0001, 2'd1, w);
    check("R4 wide back-to-back wait", 64'(w), 64'd1);
    // R9: read right after a wide multiply-add to the same pair
    put(C_MACS, 32'h7FFF_FFFF, 32'h8000_0000, 2'd1, w);
    put(C_RDHI, 32'd0, 32'd0, 2'd1, w);
    check("R9 read waits for in-flight write", 64'(w), 64'd1);
    check("R9 read after write", {32'd0, res_data}, {32'd0, mdl[1][63:32]});
    // R3: multiply-subtract forms
    put(C_MSBS, 32'hFFFF_0000, 32'h0001_0003, 2'd2, w);
    put(C_MSBU, 32'h0000_0007, 32'd9, 2'd2, w);
    read_all("R3 multiply-subtract");

    // R5
    low_mul(32'hFFFF_FFF9, 32'd6);
    low_mul(32'h1234_5678, 32'h9ABC_DEF0);

    // R6 / R8 directed divides
    divide(C_DIVU, 32'd100, 32'd7, 2'd0, "R6 unsigned");
    divide(C_DIVS, 32'hFFFF_FF9C, 32'd7, 2'd1, "R6 negative dividend");
    divide(C_DIVS, 32'd100, 32'hFFFF_FFF9, 2'd2, "R6 negative divisor");
    divide(C_DIVS, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 2'd3, "R6 both negative");
    divide(C_DIVS, 32'h8000_0000, 32'hFFFF_FFFF, 2'd0, "R6 most negative by -1");
    divide(C_DIVU, 32'hFFFF_FFFF, 32'd1, 2'd1, "R6 unsigned max");
    divide(C_DIVS, 32'hFFFF_FF00, 32'd0, 2'd2, "R8 signed by zero");
    divide(C_DIVU, 32'h8765_4321, 32'd0, 2'd3, "R8 unsigned by zero");
    divide(C_DIVS, 32'd12345, 32'd0, 2'd0, "R8 signed positive by zero");

    // R7: operation offered during a divide is taken once
    put(C_DIVU, 32'd1000, 32'd3, 2'd1, w);
    put(C_MACS, 32'd11, 32'd13, 2'd0, w);
    check("R7 offered during divide wait", 64'(w), 64'd33);
    read_all("R7 taken once");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      op = 4'($urandom_range(0, 5));
      a  = $urandom;
      if ($urandom_range(0, 1) == 1)
        b = signed_form(op) ? {{16{$urandom_range(0, 1) == 1}}, 16'($urandom)} & 32'hFFFF_FFFF
                            : {16'd0, 16'($urandom)};
      else
        b = $urandom;
      if (signed_form(op) && b[31:16] != 16'hFFFF && b[31:16] != 16'h0000 && $urandom_range(0, 3) == 0)
        b = {{16{b[15]}}, b[15:0]};
      s = 2'($urandom_range(0, 3));
      put(op, a, b, s, w);
      if (i % 8 == 7) read_all("R3 random accumulate");
      if (i % 40 == 20) begin
        divide(($urandom_range(0, 1) == 1) ? C_DIVS : C_DIVU, $urandom,
               ($urandom_range(0, 7) == 0) ? 32'd0 : ($urandom >> $urandom_range(0, 30)),
               2'($urandom_range(0, 3)), "R6 random divide");
      end
      if (i % 50 == 33) low_mul($urandom, ($urandom_range(0, 1) == 1) ? $urandom : 32'($urandom_range(0, 32767)));
    end
    read_all("R2 final pairs");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule